// File: doc/BRIEF.md
# Register-Bus General-Purpose I/O Port

This block is one general-purpose I/O port of `WIDTH` pins (eight by default) on a simple register bus. Software reaches three registers through a two-bit register select: a level register, a direction register and a read-only pin-sample register. The level register has two jobs. On a pin whose direction bit is 1 it sets the level driven onto the pad. On a pin whose direction bit is 0 it switches that pin's pull-up on or off.

Besides whole-register loads, the bus accepts set-one-bit and clear-one-bit operations that take a bit index. Software can therefore change one pin without a read-modify-write sequence that could disturb the other pins. A global pull-up-off input forces every pull-up off. Each pin also has an override enable that hands its output enable and output level to an alternate function and keeps its pull-up off. Pad inputs reach the pin-sample register through a two-flop synchronizer.

Top module: `gpio_port_ctrl`

## Requirements
- R1: A synchronous reset clears the level and direction registers, the synchronizer flops and `rd_data`. Every pin is then an input with its pull-up off.
- R2: A write with `reg_op`=0 (load) loads `wr_data` into the level register (`reg_sel`=0) or the direction register (`reg_sel`=1). A read raised at a clock edge returns that register's value from before the edge in `rd_data`, one cycle later.
- R3: A write with `reg_op`=1 (set) sets bit `bit_idx` of the selected register and leaves every other bit unchanged.
- R4: A write with `reg_op`=2 (clear) clears bit `bit_idx` of the selected register and leaves every other bit unchanged.
- R5: A write to `reg_sel`=2 (pin sample) or `reg_sel`=3 (unused) changes nothing. A write with `reg_op`=3 changes nothing.
- R6: A read of `reg_sel`=2 returns the output of the second synchronizer flop. A pad value held across two rising edges is returned by a read raised at the following edge.
- R7: Where the override is off, `pad_oe` equals the direction register and `pad_out` equals the level register.
- R8: Where the override is off and `pullup_off` is low, `pad_pu[n]` is 1 exactly when direction bit n is 0 and level bit n is 1.
- R9: While `pullup_off` is high, every bit of `pad_pu` is 0.
- R10: While `alt_en[n]` is high, `pad_oe[n]` follows `alt_oe[n]`, `pad_out[n]` follows `alt_out[n]` and `pad_pu[n]` is 0. Other pins are unaffected.
- R11: A read of `reg_sel`=3 returns 0. `rd_data` holds its value in cycles without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel | input | 2 | Register select: 0 level, 1 direction, 2 pin sample, 3 unused |
| reg_op | input | 2 | Write kind: 0 load, 1 set bit, 2 clear bit, 3 none |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wr_data | input | WIDTH | Load value |
| bit_idx | input | $clog2(WIDTH) | Bit index for set and clear |
| rd_data | output | WIDTH | Registered read result |
| pad_in | input | WIDTH | Asynchronous pad inputs |
| pullup_off | input | 1 | Global pull-up disable |
| alt_en | input | WIDTH | Per-pin alternate-function override enable |
| alt_oe | input | WIDTH | Alternate-function output enables |
| alt_out | input | WIDTH | Alternate-function output levels |
| pad_oe | output | WIDTH | Output enable to the pads |
| pad_out | output | WIDTH | Output level to the pads |
| pad_pu | output | WIDTH | Pull-up enable to the pads |

## Verification
The checker checks several behaviours on every clock:
- the pad-side rules: global pull-up masking, override takeover, and pull-up derivation from direction and level;
- that set and clear change exactly one bit;
- that writes to the pin-sample address leave both registers untouched;
- that a pin-sample read returns the synchronizer output;
- that reset clears the registers.

The bench's cycle-accurate reference model adds what the properties cannot show. It checks end-to-end read-back of written values and the two-edge latency from a pad change to a read. It also checks that `rd_data` holds between reads, and that long mixed sequences of loads, bit operations, overrides and resets match the requirements at the ports.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_LEVEL = 2'd0,
      SEL_DIR   = 2'd1,
      SEL_PIN   = 2'd2,
      SEL_NONE  = 2'd3
   } reg_sel_e;

   typedef enum logic [1:0] {
      OP_LOAD = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_NOP  = 2'd3
   } reg_op_e;

endpackage

// File: rtl/gpio_bitop_reg.sv
module gpio_bitop_reg
   import gpio_port_pkg::*;
#(
   parameter int W  = 8,
   parameter int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          hit,
   input  reg_op_e       op,
   input  logic [W-1:0]  wdata,
   input  logic [IW-1:0] idx,
   output logic [W-1:0]  q
);

   localparam logic [W-1:0] ONE_HOT_BASE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] bit_mask;
   logic [W-1:0] q_next;

   assign bit_mask = ONE_HOT_BASE << idx;

   always_comb begin
      q_next = q;
      if (hit) begin
         unique case (op)
            OP_LOAD: q_next = wdata;
            OP_SET:  q_next = q | bit_mask;
            OP_CLR:  q_next = q & ~bit_mask;
            default: q_next = q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_next;
   end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage[0] <= '0;
               else     stage[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage[s] <= '0;
               else     stage[s] <= stage[s-1];
            end
         end
      end
   endgenerate

   assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int W = 8
) (
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] level_q,
   input  logic         pullup_off,
   input  logic [W-1:0] alt_en,
   input  logic [W-1:0] alt_oe,
   input  logic [W-1:0] alt_out,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_pu
);

   generate
      for (genvar n = 0; n < W; n++) begin : g_pin
         always_comb begin
            if (alt_en[n]) begin
               pad_oe[n]  = alt_oe[n];
               pad_out[n] = alt_out[n];
               pad_pu[n]  = 1'b0;
            end else begin
               pad_oe[n]  = dir_q[n];
               pad_out[n] = level_q[n];
               pad_pu[n]  = ~dir_q[n] & level_q[n] & ~pullup_off;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int IDX_W      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       reg_sel,
   input  logic [1:0]       reg_op,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [IDX_W-1:0] bit_idx,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pad_in,
   input  logic             pullup_off,
   input  logic [WIDTH-1:0] alt_en,
   input  logic [WIDTH-1:0] alt_oe,
   input  logic [WIDTH-1:0] alt_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("gpio_port_ctrl: WIDTH must lie in 2..64");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   reg_sel_e         sel;
   reg_op_e          op;
   logic [WIDTH-1:0] level_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_q;
   logic [WIDTH-1:0] rd_mux;

   assign sel = reg_sel_e'(reg_sel);
   assign op  = reg_op_e'(reg_op);

   gpio_bitop_reg #(.W(WIDTH), .IW(IDX_W)) u_level (
      .clk   (clk),
      .rst   (rst),
      .hit   (wr_en && (sel == SEL_LEVEL)),
      .op    (op),
      .wdata (wr_data),
      .idx   (bit_idx),
      .q     (level_q)
   );

   gpio_bitop_reg #(.W(WIDTH), .IW(IDX_W)) u_dir (
      .clk   (clk),
      .rst   (rst),
      .hit   (wr_en && (sel == SEL_DIR)),
      .op    (op),
      .wdata (wr_data),
      .idx   (bit_idx),
      .q     (dir_q)
   );

   gpio_in_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pad_in),
      .q   (pin_q)
   );

   gpio_pad_mux #(.W(WIDTH)) u_mux (
      .dir_q      (dir_q),
      .level_q    (level_q),
      .pullup_off (pullup_off),
      .alt_en     (alt_en),
      .alt_oe     (alt_oe),
      .alt_out    (alt_out),
      .pad_oe     (pad_oe),
      .pad_out    (pad_out),
      .pad_pu     (pad_pu)
   );

   always_comb begin
      unique case (sel)
         SEL_LEVEL: rd_mux = level_q;
         SEL_DIR:   rd_mux = dir_q;
         SEL_PIN:   rd_mux = pin_q;
         default:   rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)        rd_data <= '0;
      else if (rd_en) rd_data <= rd_mux;
   end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       reg_sel,
   input logic [1:0]       reg_op,
   input logic             wr_en,
   input logic             rd_en,
   input logic [IDX_W-1:0] bit_idx,
   input logic [WIDTH-1:0] rd_data,
   input logic             pullup_off,
   input logic [WIDTH-1:0] alt_en,
   input logic [WIDTH-1:0] alt_oe,
   input logic [WIDTH-1:0] alt_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu,
   input logic [WIDTH-1:0] dir_q,
   input logic [WIDTH-1:0] level_q,
   input logic [WIDTH-1:0] pin_q
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (dir_q == '0) && (level_q == '0) && (rd_data == '0));

   assert_set_one_bit_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_op == 2'd1 && reg_sel == 2'd1)
      |=> dir_q == ($past(dir_q) | (ONE << $past(bit_idx))));

   assert_clear_one_bit_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_op == 2'd2 && reg_sel == 2'd0)
      |=> level_q == ($past(level_q) & ~(ONE << $past(bit_idx))));

   assert_pin_write_ignored_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && reg_sel[1])
      |=> $stable(dir_q) && $stable(level_q));

   assert_pin_read_sync_R6: assert property (@(posedge clk) disable iff (rst)
      (rd_en && reg_sel == 2'd2) |=> rd_data == $past(pin_q));

   assert_pullup_rule_R8: assert property (@(posedge clk) disable iff (rst)
      (pad_pu & ~alt_en) == (~dir_q & level_q & ~alt_en & {WIDTH{~pullup_off}}));

   assert_pullup_global_off_R9: assert property (@(posedge clk) disable iff (rst)
      pullup_off |-> pad_pu == '0);

   assert_override_takes_pin_R10: assert property (@(posedge clk) disable iff (rst)
      ((pad_oe & alt_en) == (alt_oe & alt_en)) &&
      ((pad_out & alt_en) == (alt_out & alt_en)) &&
      ((pad_pu & alt_en) == '0));

   assert_read_hold_R11: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rd_data));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .reg_sel    (reg_sel),
   .reg_op     (reg_op),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .bit_idx    (bit_idx),
   .rd_data    (rd_data),
   .pullup_off (pullup_off),
   .alt_en     (alt_en),
   .alt_oe     (alt_oe),
   .alt_out    (alt_out),
   .pad_oe     (pad_oe),
   .pad_out    (pad_out),
   .pad_pu     (pad_pu),
   .dir_q      (dir_q),
   .level_q    (level_q),
   .pin_q      (pin_q)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] reg_sel = '0;
   logic [1:0] reg_op = '0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] bit_idx = '0;
   logic [7:0] rd_data;
   logic [7:0] pad_in = '0;
   logic       pullup_off = 1'b0;
   logic [7:0] alt_en = '0;
   logic [7:0] alt_oe = '0;
   logic [7:0] alt_out = '0;
   logic [7:0] pad_oe, pad_out, pad_pu;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   logic [7:0] m_level = '0, m_dir = '0, m_rd = '0;
   logic [7:0] m_pipe [$];

   always #4 clk = ~clk;

   gpio_port_ctrl u0 (
      .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_op(reg_op),
      .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .bit_idx(bit_idx),
      .rd_data(rd_data), .pad_in(pad_in), .pullup_off(pullup_off),
      .alt_en(alt_en), .alt_oe(alt_oe), .alt_out(alt_out),
      .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   initial begin
      m_pipe.push_back(8'h00);
      m_pipe.push_back(8'h00);
   end

   // behavioural model: pipe[0] is the newest sample, pipe[1] the visible one
   always @(posedge clk) begin
      logic [7:0] upd;
      if (rst) begin
         m_level = '0; m_dir = '0; m_rd = '0;
         m_pipe[0] = '0; m_pipe[1] = '0;
      end else begin
         if (rd_en)
            m_rd = (reg_sel == 2'd0) ? m_level :
                   (reg_sel == 2'd1) ? m_dir :
                   (reg_sel == 2'd2) ? m_pipe[1] : 8'h00;
         if (wr_en && reg_sel < 2) begin
            upd = (reg_sel == 0) ? m_level : m_dir;
            if (reg_op == 0)      upd = wr_data;
            else if (reg_op == 1) upd[bit_idx] = 1'b1;
            else if (reg_op == 2) upd[bit_idx] = 1'b0;
            if (reg_sel == 0) m_level = upd; else m_dir = upd;
         end
         m_pipe[1] = m_pipe[0];
         m_pipe[0] = pad_in;
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      logic [7:0] e_oe, e_out, e_pu;
      for (int n = 0; n < 8; n++) begin
         if (alt_en[n]) begin
            e_oe[n] = alt_oe[n]; e_out[n] = alt_out[n]; e_pu[n] = 1'b0;
         end else begin
            e_oe[n] = m_dir[n]; e_out[n] = m_level[n];
            e_pu[n] = !m_dir[n] && m_level[n] && !pullup_off;
         end
      end
      chk("R7 R10 pad_oe", pad_oe, e_oe);
      chk("R7 R10 pad_out", pad_out, e_out);
      chk("R8 R9 R10 pad_pu", pad_pu, e_pu);
      chk("R2 R6 R11 rd_data", rd_data, m_rd);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      model_cmp();
   endtask

   task automatic bus_wr(logic [1:0] s, logic [1:0] o, logic [7:0] d, logic [2:0] i);
      reg_sel = s; reg_op = o; wr_data = d; bit_idx = i; wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(logic [1:0] s, output logic [7:0] v);
      reg_sel = s; rd_en = 1'b1;
      tick();
      rd_en = 1'b0;
      v = rd_data;
   endtask

   initial begin
      logic [7:0] v;
      @(negedge clk);
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      // R1: reset state
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 pad_pu", pad_pu, 8'h00);
      chk("R1 rd_data", rd_data, 8'h00);

      // R2: loads and read-back
      bus_wr(2'd0, 2'd0, 8'hA5, 3'd0);
      bus_rd(2'd0, v); chk("R2 level readback", v, 8'hA5);
      bus_wr(2'd1, 2'd0, 8'h00, 3'd0);
      // R3: set one bit of direction
      bus_wr(2'd1, 2'd1, 8'hFF, 3'd3);
      bus_rd(2'd1, v); chk("R3 dir set bit3", v, 8'h08);
      bus_wr(2'd1, 2'd1, 8'h00, 3'd7);
      bus_rd(2'd1, v); chk("R3 dir set bit7", v, 8'h88);
      // R4: clear one bit of level
      bus_wr(2'd0, 2'd2, 8'h00, 3'd0);
      bus_rd(2'd0, v); chk("R4 level clear bit0", v, 8'hA4);
      bus_wr(2'd0, 2'd2, 8'hFF, 3'd5);
      bus_rd(2'd0, v); chk("R4 level clear bit5", v, 8'h84);
      // R5: writes with no effect
      bus_wr(2'd2, 2'd0, 8'hFF, 3'd0);
      bus_wr(2'd3, 2'd1, 8'hFF, 3'd1);
      bus_wr(2'd0, 2'd3, 8'h00, 3'd2);
      bus_rd(2'd0, v); chk("R5 level unchanged", v, 8'h84);
      bus_rd(2'd1, v); chk("R5 dir unchanged", v, 8'h88);
      // R6: synchronizer latency
      pad_in = 8'h3C;
      bus_rd(2'd2, v); chk("R6 pin before first edge", v, 8'h00);
      bus_rd(2'd2, v); chk("R6 pin after one edge", v, 8'h00);
      bus_rd(2'd2, v); chk("R6 pin after two edges", v, 8'h3C);
      // R7: output pins follow registers
      bus_wr(2'd1, 2'd0, 8'hFF, 3'd0);
      chk("R7 pad_oe all out", pad_oe, 8'hFF);
      chk("R7 pad_out level", pad_out, 8'h84);
      chk("R8 no pullup on outputs", pad_pu, 8'h00);
      // R8: pull-ups on inputs
      bus_wr(2'd1, 2'd0, 8'h0F, 3'd0);
      bus_wr(2'd0, 2'd0, 8'hF3, 3'd0);
      chk("R8 pad_pu inputs", pad_pu, 8'hF0);
      // R9: global pull-up disable
      pullup_off = 1'b1; tick();
      chk("R9 pad_pu forced off", pad_pu, 8'h00);
      pullup_off = 1'b0; tick();
      chk("R9 pad_pu restored", pad_pu, 8'hF0);
      // R10: override on pins 4 and 1
      alt_en = 8'h12; alt_oe = 8'h10; alt_out = 8'h02; tick();
      chk("R10 pad_oe", pad_oe, 8'h1D);
      chk("R10 pad_out", pad_out, 8'hE3);
      chk("R10 pad_pu", pad_pu, 8'hE0);
      alt_en = '0; tick();
      // R11: unused address reads zero, hold between reads
      bus_rd(2'd3, v); chk("R11 unused reads zero", v, 8'h00);
      bus_rd(2'd0, v);
      tick(); tick();
      chk("R11 rd_data held", rd_data, 8'hF3);

      // mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         logic [31:0] r;
         r = $urandom;
         rst = (r[31:26] == 6'd0);
         reg_sel = r[1:0]; reg_op = r[3:2];
         wr_en = r[4]; rd_en = r[5];
         bit_idx = r[8:6]; wr_data = r[16:9];
         pad_in = r[24:17];
         pullup_off = (r[30:28] == 3'd0);
         alt_en = (r[25]) ? 8'($urandom) : 8'h00;
         alt_oe = 8'($urandom); alt_out = 8'($urandom);
         tick();
      end
      rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      tick();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule